// File: doc/BRIEF.md
# Load-Use Stall Controller

This block sits in the decode stage of a five-stage in-order pipeline. Each cycle it looks at the instruction in the decode/execute register and at the instruction being decoded. It decides whether the decoder must wait one cycle for a load that has not yet brought its data back from memory. The check needs two things: the decode/execute slot must hold a memory read, and that load's target register must be one of the two source registers of the instruction being decoded.

When the hazard is present, the block stops the program counter and the fetch/decode register from updating. It also raises a bubble signal that zeroes every control bit written into the decode/execute register. The instruction in decode is therefore decoded again, the next instruction is fetched again, and a no-op moves on through execute, memory and writeback.

One cycle later the load has moved to the memory stage, so the decode/execute slot holds the bubble with its read flag low. The stall then ends by itself, and the load data can be forwarded from the memory/writeback register to execute. Register zero always reads as a constant, so a load that targets it never causes a stall.

Top module: `hz_loaduse_ctrl`

## Requirements
- R1: When the decode/execute read flag is 1 and its target register number is nonzero and equal to the decoding instruction's first source field, `bubble_o` is 1 in the same cycle.
- R2: When the decode/execute read flag is 1 and its target register number is nonzero and equal to the decoding instruction's second source field, `bubble_o` is 1 in the same cycle.
- R3: When the decode/execute read flag is 0, no stall is raised, whatever the register numbers are.
- R4: A load whose target register number is 0 never raises a stall, even when a source field is also 0.
- R5: During a stall, `pc_we_o` = 0, `ifid_we_o` = 0 and `bubble_o` = 1, all in the same cycle.
- R6: With no hazard, `pc_we_o` = 1, `ifid_we_o` = 1 and `bubble_o` = 0.
- R7: A load followed directly by an instruction that reads the load's target gives exactly one bubble cycle. The dependent instruction then enters execute once, with no instruction skipped or repeated.
- R8: Back-to-back loads whose targets are not read by the instructions that follow them cause no stall cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; it samples only the embedded checks |
| rst_n | input | 1 | Active-low reset; it gates only the embedded checks |
| idex_mem_rd_i | input | 1 | Decode/execute slot holds a memory read |
| idex_rt_i | input | REG_W | Target register number of that memory read |
| ifid_rs_i | input | REG_W | First source register field of the instruction in decode |
| ifid_rt_i | input | REG_W | Second source register field of the instruction in decode |
| pc_we_o | output | 1 | Program counter write enable |
| ifid_we_o | output | 1 | Fetch/decode register write enable |
| bubble_o | output | 1 | Zero the control bits entering decode/execute |

## Verification
Two detections can fire in the same cycle: the first-source match and the second-source match, when an instruction reads the load's target through both of its source fields. A separate coincidence occurs when a load targets register zero while a source field is also zero; here the zero guard must win over the match. The sweep covers every combination of read flag, target and both source fields, so both coincidences appear. A single stall, or no stall in the zero-target case, is the only accepted response. A cycle model of the pipeline in the bench then runs short programs and counts the bubbles that actually enter execute.

// File: rtl/hz_pkg.sv
package hz_pkg;

  // Pipeline steering produced by the stall decision
  typedef struct packed {
    logic pc_we;
    logic ifid_we;
    logic bubble;
  } hz_ctl_t;

  // One stall decision drives all three actions together
  function automatic hz_ctl_t ctl_for(input logic stall);
    hz_ctl_t c;
    c.pc_we   = ~stall;
    c.ifid_we = ~stall;
    c.bubble  = stall;
    return c;
  endfunction

endpackage

// File: rtl/hz_src_match.sv
module hz_src_match #(
  parameter int unsigned REG_W      = 5,
  parameter int unsigned NUM_SRC    = 2,
  parameter bit          ZERO_CONST = 1'b1
) (
  input  logic                            ex_mem_rd,
  input  logic [REG_W-1:0]                ex_dst,
  input  logic [NUM_SRC-1:0][REG_W-1:0]   id_src,
  output logic                            load_live,
  output logic [NUM_SRC-1:0]              hit_vec
);

  // A load to a hard-wired zero register produces nothing to wait for
  function automatic logic dst_is_real(input logic [REG_W-1:0] r);
    return (ZERO_CONST == 1'b0) || (r != '0);
  endfunction

  function automatic logic same_reg(input logic [REG_W-1:0] a,
                                    input logic [REG_W-1:0] b);
    return a == b;
  endfunction

  assign load_live = ex_mem_rd && dst_is_real(ex_dst);

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    assign hit_vec[g] = load_live && same_reg(ex_dst, id_src[g]);
  end

endmodule

// File: rtl/hz_stall_ctl.sv
module hz_stall_ctl #(
  parameter int unsigned NUM_SRC = 2
) (
  input  logic [NUM_SRC-1:0] hit_vec,
  output logic               stall,
  output hz_pkg::hz_ctl_t    ctl
);

  assign stall = |hit_vec;

  always_comb begin
    ctl = hz_pkg::ctl_for(stall);
  end

endmodule

// File: rtl/hz_loaduse_ctrl.sv
module hz_loaduse_ctrl #(
  parameter int unsigned REG_W      = 5,
  parameter bit          ZERO_CONST = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idex_mem_rd_i,
  input  logic [REG_W-1:0] idex_rt_i,
  input  logic [REG_W-1:0] ifid_rs_i,
  input  logic [REG_W-1:0] ifid_rt_i,
  output logic             pc_we_o,
  output logic             ifid_we_o,
  output logic             bubble_o
);

  localparam int unsigned NUM_SRC = 2;
  localparam int unsigned SRC_RS  = 0;
  localparam int unsigned SRC_RT  = 1;

  logic [NUM_SRC-1:0][REG_W-1:0] src_fields;
  logic [NUM_SRC-1:0]            hit_vec;
  logic                          load_live;
  logic                          stall;
  hz_pkg::hz_ctl_t               ctl;

  assign src_fields[SRC_RS] = ifid_rs_i;
  assign src_fields[SRC_RT] = ifid_rt_i;

  hz_src_match #(
    .REG_W     (REG_W),
    .NUM_SRC   (NUM_SRC),
    .ZERO_CONST(ZERO_CONST)
  ) u_match (
    .ex_mem_rd(idex_mem_rd_i),
    .ex_dst   (idex_rt_i),
    .id_src   (src_fields),
    .load_live(load_live),
    .hit_vec  (hit_vec)
  );

  hz_stall_ctl #(
    .NUM_SRC(NUM_SRC)
  ) u_ctl (
    .hit_vec(hit_vec),
    .stall  (stall),
    .ctl    (ctl)
  );

  assign pc_we_o   = ctl.pc_we;
  assign ifid_we_o = ctl.ifid_we;
  assign bubble_o  = ctl.bubble;

  AST_RS_HIT_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (idex_mem_rd_i && idex_rt_i != '0 && idex_rt_i == ifid_rs_i) |-> bubble_o); // R1
  AST_RT_HIT_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (idex_mem_rd_i && idex_rt_i != '0 && idex_rt_i == ifid_rt_i) |-> bubble_o); // R2
  AST_NO_READ_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    !idex_mem_rd_i |-> !bubble_o); // R3
  AST_ZERO_DST_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (ZERO_CONST && idex_rt_i == '0) |-> (!bubble_o && !load_live)); // R4
  AST_HOLD_PC: assert property (@(posedge clk) disable iff (!rst_n)
    bubble_o |-> !pc_we_o); // R5
  AST_HOLD_IFID: assert property (@(posedge clk) disable iff (!rst_n)
    bubble_o |-> !ifid_we_o); // R5
  AST_FREE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_vec == '0) |-> (pc_we_o && ifid_we_o && !bubble_o)); // R6

endmodule

// File: tb/hz_loaduse_ctrl_tb.sv
module hz_loaduse_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int RW         = 5;
  localparam int NREG       = 1 << RW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mem_rd = 1'b0;
  logic [RW-1:0] ex_rt = '0;
  logic [RW-1:0] id_rs = '0;
  logic [RW-1:0] id_rt = '0;
  logic          pc_we, ifid_we, bubble;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hz_loaduse_ctrl #(.REG_W(RW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .idex_mem_rd_i(mem_rd), .idex_rt_i(ex_rt),
    .ifid_rs_i(id_rs), .ifid_rt_i(id_rt),
    .pc_we_o(pc_we), .ifid_we_o(ifid_we), .bubble_o(bubble)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d (rd=%0b ex_rt=%0d rs=%0d rt=%0d)",
               req, act, exp, mem_rd, ex_rt, id_rs, id_rt);
    end
  endtask

  // program store for the pipeline model
  bit ld  [8];
  int dst [8];
  int srs [8];
  int srt [8];

  task automatic set_ins(input int i, input bit l, input int d, input int s, input int t);
    ld[i] = l; dst[i] = d; srs[i] = s; srt[i] = t;
  endtask

  // Cycle model: IF/ID and ID/EX registers steered by the DUT outputs
  task automatic run_prog(input string req, input int n, input int exp_bub);
    int pc = 0;
    int fd_idx = -1;
    int dx_idx = -1;
    int next_expect = 0;
    int bubbles = 0;
    int prev_bub = 0;
    int order_ok = 1;
    int run_ok = 1;
    for (int cyc = 0; cyc < n + 6; cyc++) begin
      mem_rd = (dx_idx >= 0) ? ld[dx_idx] : 1'b0;
      ex_rt  = (dx_idx >= 0) ? RW'(dst[dx_idx]) : '0;
      id_rs  = (fd_idx >= 0) ? RW'(srs[fd_idx]) : '0;
      id_rt  = (fd_idx >= 0) ? RW'(srt[fd_idx]) : '0;
      #1;
      if (bubble) bubbles++;
      if (bubble && prev_bub) run_ok = 0;
      prev_bub = int'(bubble);
      // advance registers
      if (bubble) dx_idx = -1;
      else begin
        dx_idx = fd_idx;
        if (fd_idx >= 0) begin
          if (fd_idx != next_expect) order_ok = 0;
          next_expect++;
        end
      end
      if (ifid_we) fd_idx = (pc < n) ? pc : -1;
      if (pc_we && pc < n) pc++;
      @(negedge clk);
    end
    check({req, " bubble count"}, bubbles, exp_bub);
    check({req, " in-order issue"}, order_ok, 1);
    check({req, " issued all"}, next_expect, n);
    check({req, " single-cycle stall"}, run_ok, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R6 reset state pc_we", int'(pc_we), 1);
    check("R6 reset state ifid_we", int'(ifid_we), 1);
    check("R6 reset state bubble", int'(bubble), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // exhaustive sweep: read flag x target x both sources
    for (int m = 0; m < 2; m++) begin
      for (int d = 0; d < NREG; d++) begin
        for (int s = 0; s < NREG; s++) begin
          for (int t = 0; t < NREG; t++) begin
            int exp_st;
            string tag;
            mem_rd = m[0];
            ex_rt  = RW'(d);
            id_rs  = RW'(s);
            id_rt  = RW'(t);
            exp_st = (m == 1 && d != 0 && (d == s || d == t)) ? 1 : 0;
            if (exp_st == 1 && d == s && d == t) tag = "R1/R2 both R5";
            else if (exp_st == 1 && d == s)      tag = "R1 R5";
            else if (exp_st == 1)                tag = "R2 R5";
            else if (m == 0)                     tag = "R3 R6";
            else if (d == 0)                     tag = "R4 R6";
            else                                 tag = "R6";
            #(CLK_PERIOD/4);
            check(tag, {int'(bubble), int'(pc_we), int'(ifid_we)} == {exp_st, 1 - exp_st, 1 - exp_st} ? 1 : 0, 1);
            @(negedge clk);
          end
        end
      end
    end

    // R8: two independent loads, then an unrelated instruction
    set_ins(0, 1, 1, 3, 1);
    set_ins(1, 1, 2, 4, 2);
    set_ins(2, 0, 5, 6, 7);
    run_prog("R8 independent loads", 3, 0);

    // R7: load r8 then consumer on first source
    set_ins(0, 1, 8, 2, 8);
    set_ins(1, 0, 9, 8, 3);
    set_ins(2, 0, 10, 4, 5);
    run_prog("R7 dependent via rs", 3, 1);

    // R7 / R2: consumer reads via second source
    set_ins(0, 1, 9, 1, 9);
    set_ins(1, 0, 10, 4, 9);
    set_ins(2, 0, 11, 9, 9);
    run_prog("R7 R2 dependent via rt", 3, 1);

    // R4: load to register zero, consumer names zero
    set_ins(0, 1, 0, 1, 0);
    set_ins(1, 0, 3, 0, 0);
    run_prog("R4 zero target", 2, 0);

    // R7: two loads each followed by a consumer
    set_ins(0, 1, 12, 1, 12);
    set_ins(1, 0, 13, 12, 12);
    set_ins(2, 1, 14, 2, 14);
    set_ins(3, 0, 15, 3, 14);
    run_prog("R7 repeated pairs", 4, 2);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule